// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns the system clock into the sampling strobe a UART needs: a single-cycle pulse that fires sixteen times per bit period. Software programs the rate through two registers: a control word and a 13-bit reload value. The control word carries a run enable, a prescaler select and a fractional-mode bit that is only stored.

The strobe period in clock cycles is the reload value plus one, multiplied by two when the prescaler select is 0. In that setting an extra divide-by-2 stage sits in front of the reload counter, which is why software programs the wanted 16x divisor halved, minus one. The expected programming order is fixed:

1. Clear the run bit.
2. Clear the fractional bit.
3. Clear the prescaler select.
4. Write the reload value.
5. Set the run bit.

The reload register refuses writes while the generator runs. While stopped, the prescaler and counter sit at their reset state, so restarting always gives one full period before the first strobe. The fastest setting (prescaler bypassed, reload 0) gives a strobe on every clock, which is a baud rate of clock/16.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the control word and the reload value are 0 and `tick` is low. A start with the prescaler bypassed and no reload write therefore gives a strobe every cycle.
- R2: While the run bit is 0, `tick` stays low. A stop part-way through a period discards the partial count.
- R3: Each strobe is high for exactly one cycle, except when the period is one cycle.
- R4: With the prescaler select at 0, the strobe period is 2 × (reload + 1) cycles.
- R5: With the prescaler select at 1, the divide-by-2 stage is bypassed and the period is reload + 1 cycles.
- R6: The first strobe after the run bit is stored comes exactly one full period after the clock edge that stored it.
- R7: A write to the reload register while the run bit is 1 is ignored. The period in force stays unchanged.
- R8: The fractional-mode bit is stored but has no effect on the strobe timing.
- R9: Control word fields are fixed at these positions: run enable at bit 15, fractional enable at bit 9, prescaler select at bit 8. All other bits of the control word are ignored.
- R10: The reload register is 13 bits wide. The value 8191 gives a period of 8192 cycles with the prescaler bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word write data |
| rld_we | input | 1 | Write strobe for the reload register |
| rld_wdata | input | 13 | Reload write data |
| tick | output | 1 | 16x oversampling strobe, one cycle wide |

## Verification
A register write takes effect at the clock edge on which it is presented. With the prescaler select at 1 or 0 respectively, the first strobe is due exactly reload + 1 or 2 × (reload + 1) edges after the edge that stored the run bit. Later strobes follow at the same spacing. The bench drives and samples on the falling edge and counts falling edges from the storing edge, so each measured count equals the expected period exactly. For the stop case and the ignored-write case, the bench keeps counting through the stimulus, so any strobe early or late by one cycle shows up as a miscount.

// File: rtl/baud_gen_pkg.sv
// Shared constants and types for the baud tick generator.
// Assumes a 16-bit control word; field positions are fixed here only.
package baud_gen_pkg;
    localparam int CTL_W    = 16;
    localparam int RLD_W    = 13;
    localparam int RUN_POS  = 15;
    localparam int FRAC_POS = 9;
    localparam int PSEL_POS = 8;

    typedef struct packed {
        logic run;
        logic frac;
        logic psel;
    } baud_ctl_t;

    function automatic baud_ctl_t decode_ctl(input logic [CTL_W-1:0] w);
        baud_ctl_t c;
        c.run  = w[RUN_POS];
        c.frac = w[FRAC_POS];
        c.psel = w[PSEL_POS];
        return c;
    endfunction
endpackage

// File: rtl/baud_ctl_regs.sv
// Control and reload registers of the baud tick generator.
// Assumes: reload writes are accepted only while the stored run bit is 0;
// unused control bits are dropped at decode.
module baud_ctl_regs
    import baud_gen_pkg::*;
#(
    parameter int CW = CTL_W,
    parameter int RW = RLD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [CW-1:0] ctl_wdata,
    input  logic          rld_we,
    input  logic [RW-1:0] rld_wdata,
    output baud_ctl_t     ctl_q,
    output logic [RW-1:0] reload_q
);
    // Control word: store the three decoded fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (ctl_we)
            ctl_q <= decode_ctl(ctl_wdata);
    end

    // Reload value: locked while the generator runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (rld_we && !ctl_q.run)
            reload_q <= rld_wdata;
    end
endmodule

// File: rtl/baud_prescaler.sv
// Optional divide-by-2 stage in front of the reload counter.
// Assumes: held in its reset phase while stopped; when bypassed it
// issues a step on every cycle.
module baud_prescaler (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bypass,
    output logic step
);
    logic phase;

    // Phase toggle: alternates every cycle only while dividing.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || bypass)
            phase <= 1'b0;
        else
            phase <= ~phase;
    end

    // Step enable: every cycle when bypassed, every second cycle otherwise.
    always_comb begin
        step = run && (bypass || phase);
    end
endmodule

// File: rtl/baud_counter.sv
// Reload counter producing the registered one-cycle tick.
// Assumes: counts up from 0 to the reload value on each step and wraps;
// held at 0 while stopped so a restart sees a full period.
module baud_counter #(
    parameter int RW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    logic [RW-1:0] cnt;
    logic          at_end;

    // Terminal detect: the current count has reached the reload value.
    always_comb begin
        at_end = (cnt == reload);
    end

    // Count and pulse: wrap to 0 at the end and emit one tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= step && at_end;
            if (step)
                cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Top of the baud tick generator: registers, prescaler and counter.
// Assumes software stops the generator before reprogramming the rate;
// the fractional bit is stored only.
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter int CW = CTL_W,
    parameter int RW = RLD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [CW-1:0] ctl_wdata,
    input  logic          rld_we,
    input  logic [RW-1:0] rld_wdata,
    output logic          tick
);
    baud_ctl_t     ctl_q;
    logic [RW-1:0] reload_q;
    logic          run_w;
    logic          psel_w;
    logic          step;

    // Field taps used by the datapath and the checker.
    always_comb begin
        run_w  = ctl_q.run;
        psel_w = ctl_q.psel;
    end

    baud_ctl_regs #(.CW(CW), .RW(RW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .rld_we    (rld_we),
        .rld_wdata (rld_wdata),
        .ctl_q     (ctl_q),
        .reload_q  (reload_q)
    );

    baud_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .bypass (psel_w),
        .step   (step)
    );

    baud_counter #(.RW(RW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .step   (step),
        .reload (reload_q),
        .tick   (tick)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Property checker for the baud tick generator, bound to the top.
// Assumes it observes the stored run, prescaler select and reload value.
module baud_tick_gen_chk #(
    parameter int RW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          run,
    input logic          psel,
    input logic [RW-1:0] reload
);
    // R2: a stopped generator produces no tick on the next cycle.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

    // R3: a tick lasts one cycle unless the period is a single cycle.
    assert_tick_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(psel && reload == '0)) |=> !tick);

    // R6: no tick in the cycle where the run bit has just been stored.
    assert_no_early_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !tick);

    // R7: the reload value is frozen while running.
    assert_reload_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(reload));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.RW(RW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run_w),
    .psel   (psel_w),
    .reload (reload_q)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int RW = 13;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [CW-1:0] ctl_wdata = '0;
    logic          rld_we = 1'b0;
    logic [RW-1:0] rld_wdata = '0;
    logic          tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rld_we(rld_we), .rld_wdata(rld_wdata), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Expected period from the requirements (R4, R5).
    function automatic int exp_period(input int rld, input bit psel);
        return psel ? (rld + 1) : 2 * (rld + 1);
    endfunction

    // Control word per R9: run 15, frac 9, psel 8; junk elsewhere.
    function automatic logic [CW-1:0] mk_ctl(input bit run, input bit frac,
                                             input bit psel, input logic [CW-1:0] junk);
        logic [CW-1:0] w;
        w = junk & ~(16'h8000 | 16'h0200 | 16'h0100);
        w[15] = run;
        w[9]  = frac;
        w[8]  = psel;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr_ctl(input logic [CW-1:0] w);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_rld(input int v);
        rld_we = 1'b1; rld_wdata = RW'(v);
        @(negedge clk);
        rld_we = 1'b0;
    endtask

    // Count falling edges until tick is seen; start offset already elapsed.
    task automatic wait_tick(input int start, input int limit, output int n);
        n = start;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!tick && n < limit);
    endtask

    // Program, start, and check the first tick plus two gaps.
    task automatic run_case(input int rld, input bit psel, input bit frac,
                            input logic [CW-1:0] junk, input string req);
        int n;
        int p;
        p = exp_period(rld, psel);
        wr_ctl(mk_ctl(1'b0, 1'b0, 1'b0, junk));
        wr_rld(rld);
        wr_ctl(mk_ctl(1'b1, frac, psel, junk));
        wait_tick(0, p + 5, n);
        check(n == p, {req, " R6 first tick"}, n, p);
        for (int g = 0; g < 2; g++) begin
            wait_tick(0, p + 5, n);
            check(n == p, {req, " gap"}, n, p);
        end
        if (!(psel && rld == 0)) begin
            @(negedge clk);
            check(tick == 1'b0, {req, " R3 pulse width"}, tick, 0);
            wait_tick(1, p + 5, n);
        end
    endtask

    initial begin
        int n;
        int seed;
        seed = $urandom(32'h5eed);

        // R1: tick low during and right after reset.
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R1 tick in reset", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick == 1'b0, "R1 tick after reset", tick, 0);

        // R2: never started, no tick.
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
        check(n == 0, "R2 idle ticks", n, 0);

        // R1/R5: reload reset to 0, bypass -> tick every cycle.
        wr_ctl(mk_ctl(1'b1, 1'b0, 1'b1, '0));
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
        check(n == 10, "R1 reload reset value / max rate", n, 10);

        // Directed R4 and R5.
        run_case(3, 1'b0, 1'b0, '0, "R4 divide-by-2");
        run_case(7, 1'b1, 1'b0, '0, "R5 bypass");
        run_case(0, 1'b0, 1'b0, '0, "R4 reload zero");

        // R8: fractional bit set changes nothing.
        run_case(5, 1'b0, 1'b1, '0, "R8 frac set");
        run_case(5, 1'b1, 1'b1, '0, "R8 frac set bypass");

        // R7: reload write while running is ignored.
        wr_ctl(mk_ctl(1'b0, 1'b0, 1'b0, '0));
        wr_rld(5);
        wr_ctl(mk_ctl(1'b1, 1'b0, 1'b1, '0));
        wait_tick(0, 20, n);
        check(n == 6, "R7 setup period", n, 6);
        wr_rld(20);
        wait_tick(1, 40, n);
        check(n == 6, "R7 period after ignored write", n, 6);
        wait_tick(0, 40, n);
        check(n == 6, "R7 period still old", n, 6);

        // R2: stop mid-count, stay quiet, restart gives full period.
        repeat (3) @(negedge clk);
        wr_ctl(mk_ctl(1'b0, 1'b0, 1'b1, '0));
        n = 0;
        for (int i = 0; i < 30; i++) begin
            if (tick) n++;
            @(negedge clk);
        end
        check(n == 0, "R2 ticks while stopped", n, 0);
        wr_ctl(mk_ctl(1'b1, 1'b0, 1'b1, '0));
        wait_tick(0, 20, n);
        check(n == 6, "R2 R6 restart full period", n, 6);

        // R10: widest reload.
        run_case(8191, 1'b1, 1'b0, '0, "R10 max reload");

        // R9 with random junk bits, R4/R5 random reloads.
        for (int k = 0; k < 12; k++) begin
            int r;
            bit ps;
            bit fr;
            r  = int'($urandom % 41);
            ps = 1'($urandom);
            fr = 1'($urandom);
            run_case(r, ps, fr, CW'($urandom), "R9 random fields");
        end

        wr_ctl(mk_ctl(1'b0, 1'b0, 1'b0, '0));
        @(negedge clk);
        check(tick == 1'b0, "R2 final stop", tick, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule